// File: doc/BRIEF.md
# I2C Line Conditioner with Stuck-Low Watchdog

This block sits between the SCL and SDA input pads and the protocol logic of an I2C target. Each raw line passes through a two-flop synchronizer. It then goes through a spike filter. The filter lets a new level through only after that level has held for a fixed number of system clock cycles. At the default 100 MHz system clock this number is 5 cycles, which is 50 ns. Shorter noise pulses never reach the protocol logic.

A watchdog watches the two filtered lines. While either line is low, it counts clock cycles. If the low time reaches the limit, which is 2,500,000 cycles (25 ms at 100 MHz), the block issues a single-cycle reset pulse to the serial interface and raises a status flag. The flag drops once both lines are high again.

An enable input turns the watchdog off. With the watchdog off, SCL may run arbitrarily slowly or stop altogether. With the watchdog on, the lowest usable SCL rate is bounded by the timeout.

Top module: `i2c_line_conditioner`

## Requirements
- R1: While rstN is low, sclOut and sdaOut are 1, and ifReset and toFlag are 0.
- R2: If a raw line holds a new level for fewer than FILT_CYCLES (default 5) consecutive cycles, the matching filtered output does not change.
- R3: If a raw line holds a new level for FILT_CYCLES cycles or longer, the filtered output takes that level. The change appears on the (SYNC_STAGES + FILT_CYCLES)-th rising clock edge after the raw change, which is the 7th edge with the defaults.
- R4: With toEnable at 1, the low-time counter advances on each edge where at least one filtered line is low. It returns to zero on any edge where both filtered lines are high. If one line goes high while the other is still low, the count continues.
- R5: When the counter reaches TIMEOUT_CYCLES, ifReset is 1 for exactly one cycle, on the TIMEOUT_CYCLES-th counting edge. No further pulse follows while the lines stay low.
- R6: toFlag goes to 1 together with the reset pulse. It stays at 1 while any filtered line is low and returns to 0 on the first edge where both filtered lines are high.
- R7: While toEnable is 0, the counter is held at zero, ifReset stays 0 and toFlag is 0. When toEnable returns to 1 with a line low, counting restarts from zero.
- R8: After a filtered output changes, it cannot change again on the next edge.

Note on R8: after each change, the filter needs a fresh run of FILT_CYCLES cycles at the new level before it can change again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sclRaw | input | 1 | Unsynchronized SCL level from the pad |
| sdaRaw | input | 1 | Unsynchronized SDA level from the pad |
| toEnable | input | 1 | 1 enables the stuck-low watchdog |
| sclOut | output | 1 | Filtered SCL |
| sdaOut | output | 1 | Filtered SDA |
| ifReset | output | 1 | One-cycle reset pulse for the serial interface |
| toFlag | output | 1 | Timeout status, held until both lines are high |

## Verification
The assertions check the following on every cycle:
- the reset pulse is a single cycle (R5);
- the flag is set whenever the pulse is (R6);
- the flag clears once both outputs are high (R6);
- no pulse follows a cycle with the watchdog disabled (R7);
- a filtered output never changes on two edges in a row (R8).

Only the bench scenarios can show the properties below, because each depends on exact cycle counts across a whole episode:
- the exact filter latency and the rejection of short spikes (R2, R3);
- the exact edge on which the timeout pulse appears (R5);
- that the count carries on across a hand-over between the two lines (R4);
- that the count restarts after a short release and after re-enabling (R4, R7).

// File: rtl/i2c_cond_pkg.sv
`timescale 1ns/1ps
package i2c_cond_pkg;
  localparam int LINE_COUNT = 2;
  localparam int SCL_IDX    = 0;
  localparam int SDA_IDX    = 1;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
  } toStrobe_t;
endpackage

// File: rtl/i2cc_spike_filter.sv
`timescale 1ns/1ps
module i2cc_spike_filter #(
  parameter int FILT_CYCLES = 5
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LAST_RUN = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt  <= '0;
      lineOut <= 1'b1;
    end else if (lineIn == lineOut) begin
      runCnt <= '0;
    end else if (runCnt == LAST_RUN) begin
      runCnt  <= '0;
      lineOut <= lineIn;
    end else begin
      runCnt <= runCnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2cc_datapath.sv
`timescale 1ns/1ps
module i2cc_datapath
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int FILT_CYCLES    = 5,
  parameter int TIMEOUT_CYCLES = 2500000
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [LINE_COUNT-1:0] lineRaw,
  input  toStrobe_t             strobe,
  output logic [LINE_COUNT-1:0] lineFilt,
  output logic                  cntAtLast,
  output logic                  cntFull
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] CNT_LAST = TW'(TIMEOUT_CYCLES - 1);
  localparam logic [TW-1:0] CNT_FULL = TW'(TIMEOUT_CYCLES);

  logic [TW-1:0] lowCnt;

  for (genvar g = 0; g < LINE_COUNT; g++) begin : g_line
    logic [SYNC_STAGES-1:0] syncQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '1;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineRaw[g]};
    end

    i2cc_spike_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk    (clk),
      .rstN   (rstN),
      .lineIn (syncQ[SYNC_STAGES-1]),
      .lineOut(lineFilt[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                lowCnt <= '0;
    else if (strobe.cntClear) lowCnt <= '0;
    else if (strobe.cntInc)   lowCnt <= lowCnt + 1'b1;
  end

  assign cntAtLast = (lowCnt == CNT_LAST);
  assign cntFull   = (lowCnt == CNT_FULL);
endmodule

// File: rtl/i2cc_control.sv
`timescale 1ns/1ps
module i2cc_control
  import i2c_cond_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  toEnable,
  input  logic [LINE_COUNT-1:0] lineFilt,
  input  logic                  cntAtLast,
  input  logic                  cntFull,
  output toStrobe_t             strobe,
  output logic                  ifReset,
  output logic                  toFlag
);
  logic bothHigh;
  logic hitLimit;

  always_comb begin
    bothHigh        = &lineFilt;
    strobe.cntClear = !toEnable || bothHigh;
    strobe.cntInc   = !strobe.cntClear && !cntFull;
    hitLimit        = strobe.cntInc && cntAtLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ifReset <= 1'b0;
      toFlag  <= 1'b0;
    end else begin
      ifReset <= hitLimit;
      if (strobe.cntClear) toFlag <= 1'b0;
      else if (hitLimit)   toFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_line_conditioner.sv
`timescale 1ns/1ps
module i2c_line_conditioner
  import i2c_cond_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int FILT_CYCLES    = 5,
  parameter int TIMEOUT_CYCLES = 2500000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclRaw,
  input  logic sdaRaw,
  input  logic toEnable,
  output logic sclOut,
  output logic sdaOut,
  output logic ifReset,
  output logic toFlag
);
  logic [LINE_COUNT-1:0] lineRaw;
  logic [LINE_COUNT-1:0] lineFilt;
  toStrobe_t             strobe;
  logic                  cntAtLast;
  logic                  cntFull;

  assign lineRaw[SCL_IDX] = sclRaw;
  assign lineRaw[SDA_IDX] = sdaRaw;

  i2cc_datapath #(
    .SYNC_STAGES   (SYNC_STAGES),
    .FILT_CYCLES   (FILT_CYCLES),
    .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .lineRaw  (lineRaw),
    .strobe   (strobe),
    .lineFilt (lineFilt),
    .cntAtLast(cntAtLast),
    .cntFull  (cntFull)
  );

  i2cc_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .toEnable (toEnable),
    .lineFilt (lineFilt),
    .cntAtLast(cntAtLast),
    .cntFull  (cntFull),
    .strobe   (strobe),
    .ifReset  (ifReset),
    .toFlag   (toFlag)
  );

  assign sclOut = lineFilt[SCL_IDX];
  assign sdaOut = lineFilt[SDA_IDX];
endmodule

// File: rtl/i2c_line_conditioner_chk.sv
`timescale 1ns/1ps
module i2c_line_conditioner_chk (
  input logic clk,
  input logic rstN,
  input logic toEnable,
  input logic sclOut,
  input logic sdaOut,
  input logic ifReset,
  input logic toFlag
);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ifReset |=> !ifReset);

  a_r6_flag_with_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ifReset |-> toFlag);

  a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && sdaOut) |=> !toFlag);

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !toEnable |=> (!ifReset && !toFlag));

  a_r8_scl_min_gap: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut != $past(sclOut)) |=> (sclOut == $past(sclOut)));

  a_r8_sda_min_gap: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOut != $past(sdaOut)) |=> (sdaOut == $past(sdaOut)));
endmodule

bind i2c_line_conditioner i2c_line_conditioner_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .toEnable(toEnable),
  .sclOut  (sclOut),
  .sdaOut  (sdaOut),
  .ifReset (ifReset),
  .toFlag  (toFlag)
);

// File: tb/i2c_line_conditioner_tb.sv
`timescale 1ns/1ps
module i2c_line_conditioner_tb;
  localparam int LAT  = 7;    // 2 sync stages + 5 filter cycles
  localparam int TOUT = 200;  // reduced timeout for the bench

  logic clk = 1'b0;
  logic rstN, sclRaw, sdaRaw, toEnable;
  logic sclOut, sdaOut, ifReset, toFlag;
  int   nChecks = 0;
  int   nFails  = 0;
  bit   done    = 1'b0;

  always #4 clk = ~clk;

  i2c_line_conditioner #(.TIMEOUT_CYCLES(TOUT)) u_dut (
    .clk(clk), .rstN(rstN), .sclRaw(sclRaw), .sdaRaw(sdaRaw),
    .toEnable(toEnable), .sclOut(sclOut), .sdaOut(sdaOut),
    .ifReset(ifReset), .toFlag(toFlag)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rstN = 1'b0; sclRaw = 1'b1; sdaRaw = 1'b1; toEnable = 1'b1;
    step(3);
    chk("R1 sclOut", sclOut, 1);
    chk("R1 sdaOut", sdaOut, 1);
    chk("R1 ifReset", ifReset, 0);
    chk("R1 toFlag", toFlag, 0);
    rstN = 1'b1;
    step(10);
  endtask

  task automatic t_spike();
    int lows = 0;
    sclRaw = 1'b0; step(4); sclRaw = 1'b1;
    for (int i = 0; i < 20; i++) begin step(1); if (!sclOut) lows++; end
    chk("R2 4-cycle SCL spike rejected", lows, 0);
    lows = 0;
    sdaRaw = 1'b0; step(1); sdaRaw = 1'b1;
    for (int i = 0; i < 20; i++) begin step(1); if (!sdaOut) lows++; end
    chk("R2 1-cycle SDA spike rejected", lows, 0);
  endtask

  task automatic t_pass();
    int pulses = 0;
    sclRaw = 1'b0;
    step(LAT - 1); chk("R3 SCL not yet low", sclOut, 1);
    step(1);       chk("R3 SCL low on 7th edge", sclOut, 0);
    sclRaw = 1'b1;
    step(LAT - 1); chk("R3 SCL not yet high", sclOut, 0);
    step(1);       chk("R3 SCL high on 7th edge", sclOut, 1);
    for (int i = 0; i < 10; i++) begin step(1); if (ifReset) pulses++; end
    chk("R4 short low gives no pulse", pulses, 0);
  endtask

  task automatic t_timeout();
    int pulses = 0;
    sdaRaw = 1'b0;
    step(LAT - 1); chk("R3 SDA not yet low", sdaOut, 1);
    step(1);       chk("R3 SDA low on 7th edge", sdaOut, 0);
    step(TOUT - 1); chk("R5 no pulse one cycle early", ifReset, 0);
    chk("R6 flag low before timeout", toFlag, 0);
    step(1);       chk("R5 pulse on limit edge", ifReset, 1);
    chk("R6 flag set with pulse", toFlag, 1);
    step(1);       chk("R5 pulse lasts one cycle", ifReset, 0);
    for (int i = 0; i < 100; i++) begin step(1); if (ifReset) pulses++; end
    chk("R5 no repeat pulse while low", pulses, 0);
    chk("R6 flag held while low", toFlag, 1);
    sdaRaw = 1'b1;
    step(LAT); chk("R6 flag still set as SDA rises", toFlag, 1);
    chk("R3 SDA high on 7th edge", sdaOut, 1);
    step(1);   chk("R6 flag cleared once both high", toFlag, 0);
    step(10);
  endtask

  task automatic t_handover();
    sclRaw = 1'b0; step(50);
    sdaRaw = 1'b0; step(50);
    sclRaw = 1'b1;
    step(TOUT + LAT - 101); chk("R4 handover no early pulse", ifReset, 0);
    step(1); chk("R4 count continues across handover", ifReset, 1);
    sdaRaw = 1'b1; step(20);
    chk("R6 flag cleared after handover", toFlag, 0);
  endtask

  task automatic t_restart();
    sdaRaw = 1'b0; step(150);
    sdaRaw = 1'b1; step(20);
    sdaRaw = 1'b0;
    step(TOUT + LAT - 1); chk("R4 counter restarted, no early pulse", ifReset, 0);
    step(1); chk("R4 pulse after full fresh episode", ifReset, 1);
    sdaRaw = 1'b1; step(20);
  endtask

  task automatic t_disabled();
    int pulses = 0;
    int flags  = 0;
    toEnable = 1'b0; sdaRaw = 1'b0;
    for (int i = 0; i < 2 * TOUT; i++) begin
      step(1); if (ifReset) pulses++; if (toFlag) flags++;
    end
    chk("R7 no pulse while disabled", pulses, 0);
    chk("R7 no flag while disabled", flags, 0);
    toEnable = 1'b1;
    step(TOUT - 1); chk("R7 count restarts from zero on enable", ifReset, 0);
    step(1); chk("R7 pulse after re-enable", ifReset, 1);
    toEnable = 1'b0;
    step(1); chk("R7 disable clears flag", toFlag, 0);
    sdaRaw = 1'b1; toEnable = 1'b1; step(20);
  endtask

  initial begin
    t_reset();
    t_spike();
    t_pass();
    t_timeout();
    t_handover();
    t_restart();
    t_disabled();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog R1..R8 actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule